// File: doc/BRIEF.md
# PWM Pin Multiplexer with Output Polarity

This block sits between a PWM generator and eight I/O pins. Each pin is normally a general-purpose port bit: a data latch and a direction latch are written over a small data bus, and both the latch contents and the synchronized pin level can be read back. When a complementary pair of pins is switched over to PWM, the pins stop following the latches. The PWM path then drives them as outputs, with the final level set by a polarity bit.

The PWM path first picks, for each pin, a forced fault value, a manual override value, or the live generator signal, in that order of priority. The chosen level then passes through the polarity stage. One polarity bit covers the odd-numbered (high-side) pins and another covers the even-numbered (low-side) pins. The two polarity bits, a pin-mode bit and a 3-bit pair-enable code are captured while reset is asserted. They then hold until the next reset, so the pin states are known as soon as reset is released.

Top module: `pwm_pin_mux`

## Requirements
- R1: The two polarity bits, the pin-mode bit and the enable code are loaded on every clock edge while rst is high. After rst goes low they keep the values of the last reset cycle, and later changes on those inputs have no effect until the next reset.
- R2: Pair p drives pins 2p and 2p+1. When the captured pin-mode bit is 1 and the captured enable code is c, pair p is under PWM control exactly when p < c, so codes 4 to 7 select all four pairs. When the captured pin-mode bit is 0, no pair is under PWM control.
- R3: A pin under PWM control has pin_oe = 1 whatever its direction latch bit holds.
- R4: For a pin under PWM control, the pre-polarity level is fault_val[i] when fault_act is 1. Otherwise it is ovr_val[i] when ovr_en[i] is 1. Otherwise it is pwm_in[i].
- R5: Odd-numbered pins use the high-side polarity bit and even-numbered pins use the low-side polarity bit. A polarity bit of 1 passes the pre-polarity level unchanged (active-high). A polarity bit of 0 inverts it (active-low).
- R6: Polarity is applied equally to fault and override levels, not only to the generator signal.
- R7: A pin not under PWM control has pin_out equal to its port-latch bit and pin_oe equal to its direction-latch bit, where 1 means output. Both appear one clock edge after the latch changes.
- R8: With bus_wr = 1, bus_sel = 0 loads bus_wdata into the port latch and bus_sel = 1 loads it into the direction latch on the next edge. rd_latch and rd_dir show the new value after that edge. A write to a PWM-controlled pin's latch is stored, but it does not change that pin's pin_out or pin_oe.
- R9: rd_pin equals pin_in as it was two clock edges earlier, through a two-flop synchronizer.
- R10: While rst is high, pin_out, pin_oe, rd_latch, rd_dir and rd_pin are all 0, so every pin is an input.
- R11: pin_out and pin_oe are registered. A change on the PWM, fault or override inputs appears on them one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while high |
| cfg_pol_hi | input | 1 | High-side (odd pins) polarity, 1 = active-high |
| cfg_pol_lo | input | 1 | Low-side (even pins) polarity, 1 = active-high |
| cfg_pin_mode | input | 1 | 1 = enable code applies after reset, 0 = all pins start as port I/O |
| cfg_en_code | input | 3 | Number of pairs under PWM control (4 to 7 = all) |
| pwm_in | input | 8 | Generator PWM levels, one per pin |
| ovr_en | input | 8 | Per-pin manual override enable |
| ovr_val | input | 8 | Per-pin manual override level |
| fault_act | input | 1 | Fault active, forces fault_val on all PWM pins |
| fault_val | input | 8 | Per-pin fault level |
| bus_wr | input | 1 | Bus write strobe |
| bus_sel | input | 1 | 0 = port latch, 1 = direction latch |
| bus_wdata | input | 8 | Bus write data |
| pin_in | input | 8 | Pin input levels (asynchronous) |
| pin_out | output | 8 | Pin drive level |
| pin_oe | output | 8 | Pin output enable, 1 = driving |
| rd_latch | output | 8 | Port latch readback |
| rd_dir | output | 8 | Direction latch readback |
| rd_pin | output | 8 | Synchronized pin level readback |

## Verification
PWM, fault and override inputs reach pin_out one edge after they are applied. A bus write reaches rd_latch and rd_dir one edge later and the pins one edge after that. A pin level reaches rd_pin after two edges. The bench drives every input at the falling clock edge and samples at the falling edge that follows the count of rising edges due for each path. For the synchronizer it also checks the value after the first edge, so a single-flop path is caught. All 64 reset-time configurations are swept, and each is followed by a fixed set of fault, override and generator patterns, against expected values computed from the requirements.

// File: rtl/pwm_pin_pkg.sv
package pwm_pin_pkg;
  typedef enum logic {
    SEL_PORT = 1'b0,
    SEL_DIR  = 1'b1
  } bus_sel_e;
endpackage

// File: rtl/pwm_pin_cfg.sv
// Reset-time configuration capture and pair-enable decode.
module pwm_pin_cfg #(
  parameter int NUM_PAIRS = 4,
  parameter int EN_W      = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_pol_hi,
  input  logic                 cfg_pol_lo,
  input  logic                 cfg_pin_mode,
  input  logic [EN_W-1:0]      cfg_en_code,
  output logic                 pol_hi_q,
  output logic                 pol_lo_q,
  output logic [NUM_PAIRS-1:0] pair_en
);
  logic            mode_q;
  logic [EN_W-1:0] code_q;

  // Loaded continuously while reset is held, frozen afterwards.
  always_ff @(posedge clk) begin
    if (rst) begin
      pol_hi_q <= cfg_pol_hi;
      pol_lo_q <= cfg_pol_lo;
      mode_q   <= cfg_pin_mode;
      code_q   <= cfg_en_code;
    end
  end

  // Pair p is enabled when the code exceeds its index.
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign pair_en[p] = mode_q && ({1'b0, code_q} > (EN_W+1)'(p));
  end
endmodule

// File: rtl/pwm_pin_gpio.sv
// Port and direction latches written from the bus, plus the input synchronizer.
module pwm_pin_gpio
  import pwm_pin_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_sel,
  input  logic [NUM_PINS-1:0] bus_wdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] port_q,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] sync_q
);
  logic [NUM_PINS-1:0] meta_q;
  bus_sel_e            sel;

  assign sel = bus_sel_e'(bus_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      port_q <= '0;
      dir_q  <= '0;
    end else if (bus_wr) begin
      if (sel == SEL_PORT) port_q <= bus_wdata;
      else                 dir_q  <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
    end
  end
endmodule

// File: rtl/pwm_pin_chan.sv
// One pin: fault/override/generator select, polarity, port-or-PWM mux.
module pwm_pin_chan (
  input  logic pwm,
  input  logic ovr_en,
  input  logic ovr_val,
  input  logic fault_act,
  input  logic fault_val,
  input  logic pol,
  input  logic pwm_on,
  input  logic port_bit,
  input  logic dir_bit,
  output logic drv,
  output logic oe
);
  logic sel_lvl;
  logic out_lvl;

  always_comb begin
    if (fault_act)   sel_lvl = fault_val;
    else if (ovr_en) sel_lvl = ovr_val;
    else             sel_lvl = pwm;
    out_lvl = pol ? sel_lvl : ~sel_lvl;
    drv     = pwm_on ? out_lvl : port_bit;
    oe      = pwm_on | dir_bit;
  end
endmodule

// File: rtl/pwm_pin_mux.sv
// Top: eight PWM-capable pins with reset-configured polarity.
module pwm_pin_mux #(
  parameter int NUM_PAIRS = 4,
  parameter int EN_W      = 3,
  localparam int NUM_PINS = 2 * NUM_PAIRS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_pol_hi,
  input  logic                cfg_pol_lo,
  input  logic                cfg_pin_mode,
  input  logic [EN_W-1:0]     cfg_en_code,
  input  logic [NUM_PINS-1:0] pwm_in,
  input  logic [NUM_PINS-1:0] ovr_en,
  input  logic [NUM_PINS-1:0] ovr_val,
  input  logic                fault_act,
  input  logic [NUM_PINS-1:0] fault_val,
  input  logic                bus_wr,
  input  logic                bus_sel,
  input  logic [NUM_PINS-1:0] bus_wdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] rd_latch,
  output logic [NUM_PINS-1:0] rd_dir,
  output logic [NUM_PINS-1:0] rd_pin
);
  logic                 pol_hi_q;
  logic                 pol_lo_q;
  logic [NUM_PAIRS-1:0] pair_en;
  logic [NUM_PINS-1:0]  pin_mask;
  logic [NUM_PINS-1:0]  port_q;
  logic [NUM_PINS-1:0]  dir_q;
  logic [NUM_PINS-1:0]  drv_d;
  logic [NUM_PINS-1:0]  oe_d;

  pwm_pin_cfg #(.NUM_PAIRS(NUM_PAIRS), .EN_W(EN_W)) u_cfg (
    .clk(clk), .rst(rst),
    .cfg_pol_hi(cfg_pol_hi), .cfg_pol_lo(cfg_pol_lo),
    .cfg_pin_mode(cfg_pin_mode), .cfg_en_code(cfg_en_code),
    .pol_hi_q(pol_hi_q), .pol_lo_q(pol_lo_q), .pair_en(pair_en)
  );

  pwm_pin_gpio #(.NUM_PINS(NUM_PINS)) u_gpio (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .pin_in(pin_in),
    .port_q(port_q), .dir_q(dir_q), .sync_q(rd_pin)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic pol_i;
    // Odd pins are high-side, even pins low-side.
    if (i % 2 == 1) begin : g_hi
      assign pol_i = pol_hi_q;
    end else begin : g_lo
      assign pol_i = pol_lo_q;
    end
    assign pin_mask[i] = pair_en[i/2];

    pwm_pin_chan u_chan (
      .pwm(pwm_in[i]), .ovr_en(ovr_en[i]), .ovr_val(ovr_val[i]),
      .fault_act(fault_act), .fault_val(fault_val[i]),
      .pol(pol_i), .pwm_on(pin_mask[i]),
      .port_bit(port_q[i]), .dir_bit(dir_q[i]),
      .drv(drv_d[i]), .oe(oe_d[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else begin
      pin_out <= drv_d;
      pin_oe  <= oe_d;
    end
  end

  assign rd_latch = port_q;
  assign rd_dir   = dir_q;
endmodule

// File: rtl/pwm_pin_mux_chk.sv
module pwm_pin_mux_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_wr,
  input logic                bus_sel,
  input logic [NUM_PINS-1:0] bus_wdata,
  input logic [NUM_PINS-1:0] pin_in,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] rd_latch,
  input logic [NUM_PINS-1:0] rd_dir,
  input logic [NUM_PINS-1:0] rd_pin,
  input logic [NUM_PINS-1:0] pin_mask,
  input logic                pol_hi,
  input logic                pol_lo
);
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(pol_hi) && $stable(pol_lo) && $stable(pin_mask))); // R1
  AST_PWM_OE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pin_mask & ~pin_oe) == '0)); // R3
  AST_GPIO_PATH: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((((pin_out ^ $past(rd_latch)) & ~pin_mask) == '0) &&
                     (((pin_oe ^ $past(rd_dir)) & ~pin_mask) == '0))); // R7
  AST_PORT_WR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_wr && !bus_sel)) |-> (rd_latch == $past(bus_wdata))); // R8
  AST_DIR_WR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_wr && bus_sel)) |-> (rd_dir == $past(bus_wdata))); // R8
  AST_SYNC_2FF: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (rd_pin == $past(pin_in, 2))); // R9
endmodule

bind pwm_pin_mux pwm_pin_mux_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
  .bus_wdata(bus_wdata), .pin_in(pin_in), .pin_out(pin_out),
  .pin_oe(pin_oe), .rd_latch(rd_latch), .rd_dir(rd_dir), .rd_pin(rd_pin),
  .pin_mask(pin_mask), .pol_hi(pol_hi_q), .pol_lo(pol_lo_q)
);

// File: tb/pwm_pin_mux_tb.sv
`timescale 1ns/1ps
module pwm_pin_mux_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_pol_hi = 1'b1, cfg_pol_lo = 1'b1, cfg_pin_mode = 1'b0;
  logic [2:0] cfg_en_code = '0;
  logic [7:0] pwm_in = '0, ovr_en = '0, ovr_val = '0, fault_val = '0;
  logic       fault_act = 1'b0;
  logic       bus_wr = 1'b0, bus_sel = 1'b0;
  logic [7:0] bus_wdata = '0, pin_in = '0;
  logic [7:0] pin_out, pin_oe, rd_latch, rd_dir, rd_pin;

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;

  // Expected-model state.
  logic       ph, pl;
  logic [7:0] mask, lat, dir;

  always #2.5 clk = ~clk;

  pwm_pin_mux u_dut (
    .clk(clk), .rst(rst), .cfg_pol_hi(cfg_pol_hi), .cfg_pol_lo(cfg_pol_lo),
    .cfg_pin_mode(cfg_pin_mode), .cfg_en_code(cfg_en_code),
    .pwm_in(pwm_in), .ovr_en(ovr_en), .ovr_val(ovr_val),
    .fault_act(fault_act), .fault_val(fault_val),
    .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .rd_latch(rd_latch), .rd_dir(rd_dir), .rd_pin(rd_pin)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] exp_out();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      logic s, p;
      s = fault_act ? fault_val[i] : (ovr_en[i] ? ovr_val[i] : pwm_in[i]);
      p = (i % 2 == 1) ? ph : pl;
      r[i] = mask[i] ? (p ? s : ~s) : lat[i];
    end
    return r;
  endfunction

  initial begin
    @(negedge clk);
    for (int c = 0; c < 64; c++) begin
      logic [2:0] code;
      logic       md;
      ph = c[0]; pl = c[1]; md = c[2]; code = 3'(c >> 3);
      // R2: pair p active when mode set and p < code.
      for (int i = 0; i < 8; i++) mask[i] = md && ((i / 2) < int'(code));
      lat = '0; dir = '0;
      rst = 1'b1;
      cfg_pol_hi = ph; cfg_pol_lo = pl; cfg_pin_mode = md; cfg_en_code = code;
      fault_act = 1'b0; ovr_en = '0; pin_in = '0;
      step(); step();
      // R10: all outputs are clear while reset is held.
      chk("R10 pin_out", pin_out, 8'h00);
      chk("R10 pin_oe", pin_oe, 8'h00);
      chk("R10 rd_latch", rd_latch, 8'h00);
      chk("R10 rd_dir", rd_dir, 8'h00);
      chk("R10 rd_pin", rd_pin, 8'h00);
      // R1: change the configuration inputs after release; they must be ignored.
      rst = 1'b0;
      cfg_pol_hi = ~ph; cfg_pol_lo = ~pl; cfg_pin_mode = ~md; cfg_en_code = ~code;
      step(); step();
      chk("R1 R2 R3 oe after reset", pin_oe, mask);
      // R8: write port then direction latch.
      bus_wr = 1'b1; bus_sel = 1'b0; bus_wdata = 8'h3C ^ 8'(c);
      step();
      lat = 8'h3C ^ 8'(c);
      chk("R8 rd_latch", rd_latch, lat);
      bus_sel = 1'b1; bus_wdata = 8'hA5 ^ 8'(c * 3);
      step();
      dir = 8'hA5 ^ 8'(c * 3);
      chk("R8 rd_dir", rd_dir, dir);
      bus_wr = 1'b0;
      step();
      // R7/R3/R8: port pins follow latches; PWM pins stay outputs and ignore them.
      chk("R3 R7 R8 pin_oe", pin_oe, dir | mask);
      chk("R7 R8 pin_out", pin_out, exp_out());
      // R4 R5 R6 R11: generator, override and fault patterns.
      for (int k = 0; k < 6; k++) begin
        pwm_in    = 8'(k * 53 + c * 7);
        ovr_en    = (k >= 2) ? 8'(k * 29 + c) : 8'h00;
        ovr_val   = 8'(~(k * 11 + c));
        fault_act = (k >= 4);
        fault_val = 8'(k * 77 + c);
        step();
        chk("R4 R5 R6 R11 pin_out", pin_out, exp_out());
      end
      fault_act = 1'b0;
      // R9: two-flop synchronizer, old value after one edge.
      pin_in = 8'(c * 13 + 5);
      step();
      chk("R9 rd_pin after 1 edge", rd_pin, 8'h00);
      step();
      chk("R9 rd_pin after 2 edges", rd_pin, 8'(c * 13 + 5));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R11: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule